// File: doc/BRIEF.md
# Successive-Approximation ADC Control Sequencer

This block is the digital half of a 10-bit successive-approximation converter. It drives a trial code to an external DAC and reads back one comparator bit. Over a fixed sequence of ADC clock cycles it settles the code from the most significant bit downward, then latches a 10-bit result and raises a completion flag.

The ADC clock is not a separate clock domain. It is a single-cycle enable pulse on the bus clock. The pulse is derived from either the bus clock itself or an oscillator tick input, and then divided by a programmable power of two.

Software starts a conversion by writing the control register. The prescaler runs freely, so the first ADC cycle after the write is only a partial one. The whole conversion therefore spans sixteen full ADC cycles plus that partial cycle. Sampling, the comparator and input selection live outside the block; only a channel number is kept for software.

Top module: `sar_adc_ctrl`

## Requirements
- R1: A write to address 0 starts a conversion and stores data bits [4:0] as the channel number. From the next cycle on, the status read at address 0 shows busy in bit 6 and the channel in bits [4:0].
- R2: The result is latched on the 17th ADC clock enable after the start write. With the bus clock as source and divide 1, completion is visible exactly 17 bus cycles after the write edge. In general it is visible between 16·M+1 and 17·M bus cycles after that edge, where M is the number of bus cycles per ADC cycle. No result is latched while idle.
- R3: Configuration bit 3 (address 1) selects the source: 0 is the bus clock, 1 is the oscillator tick input. With the oscillator selected, the ADC clock advances only on cycles where that tick is high.
- R4: Configuration bits [2:0] select the divide ratio: values 0, 1, 2, 3 and 4 give 1, 2, 4, 8 and 16, and values 5, 6 and 7 also give 16. The configuration byte reads back at address 1.
- R5: One bit is decided per ADC cycle, MSB first. A comparator input of 1 means the analog input is at or above the trial code on `dac_code`, and keeps that bit set. For an in-range input the result equals the input code.
- R6: An input at or above full scale converts to 0x3FF. An input at or below zero converts to 0x000.
- R7: Status bit 7 (done) sets when the result is loaded. Reading address 3 (result bits [7:0]) clears it. Reading address 2 (result bits [9:8] in data bits [1:0]) leaves it set.
- R8: A control write clears done. A control write during an active conversion abandons it and restarts the full sequence from that write.
- R9: A write to address 1 starts nothing and leaves done, busy and the result unchanged.
- R10: After reset, every register reads 0 (bus clock source, divide 1) and `dac_code` is 0.
- R11: `dac_code` changes only on an ADC clock enable or a start write. While idle it holds the final code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all logic runs on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe (side effects only) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| osc_tick | input | 1 | Oscillator clock as a one-cycle tick on the bus clock |
| cmp_in | input | 1 | Comparator: 1 when input is at or above the trial code |
| dac_code | output | 10 | Trial code driven to the DAC |

## Verification
The conversion is tried with mid-scale, odd, near-zero and full-scale input codes, and with inputs beyond both references. These separate a correct bit-by-bit decision from stuck, shifted or unclamped results. Each input is paired with a different source and divide setting. The completion latency window is measured in bus cycles, which catches a wrong ratio, a wrong source or a wrong step count; the exact 17-cycle case exposes any off-by-one in the sequence. Directed cases cover the two result reads, a restart in mid-conversion, and a configuration write against a finished result.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;

  localparam int BUS_W   = 8;
  localparam int ADDR_W  = 2;
  localparam int DIV_W   = 3;
  localparam int PRE_W   = 4;   // log2 of the largest divide ratio

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL   = 2'd0,
    REG_CLKCFG = 2'd1,
    REG_RES_HI = 2'd2,
    REG_RES_LO = 2'd3
  } reg_sel_e;

  // Low-bit mask of the free-running prescale counter: the ADC enable fires
  // when every masked bit is one. Codes above PRE_W saturate at the largest ratio.
  function automatic logic [PRE_W-1:0] div_mask(input logic [DIV_W-1:0] sel);
    int exp_v;
    logic [PRE_W:0] pow;
    exp_v = int'(sel);
    if (exp_v > PRE_W) exp_v = PRE_W;
    pow = (PRE_W+1)'(1) << exp_v;
    return PRE_W'(pow - 1'b1);
  endfunction

endpackage

// File: rtl/sar_adc_prescaler.sv
module sar_adc_prescaler
  import sar_adc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_tick,
  input  logic             src_osc,
  input  logic [DIV_W-1:0] div_sel,
  output logic             src_tick,
  output logic             adc_ce
);

  logic [PRE_W-1:0] pre_cnt;
  logic [PRE_W-1:0] pre_mask;

  always_comb begin
    src_tick = src_osc ? osc_tick : 1'b1;
    pre_mask = div_mask(div_sel);
    adc_ce   = src_tick && ((pre_cnt & pre_mask) == pre_mask);
  end

  // Free-running: a start write does not reset it, so the first ADC
  // cycle of a conversion is a partial one.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pre_cnt <= '0;
    else if (src_tick) pre_cnt <= pre_cnt + 1'b1;
  end

endmodule

// File: rtl/sar_adc_sequencer.sv
module sar_adc_sequencer #(
  parameter int RES_W      = 10,
  parameter int SAMPLE_CYC = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             adc_ce,
  input  logic             cmp_in,
  output logic             busy,
  output logic             res_load,
  output logic [RES_W-1:0] trial,
  output logic [RES_W-1:0] code_out
);

  localparam int STEP_TRIAL = SAMPLE_CYC;
  localparam int STEP_LAST  = SAMPLE_CYC + RES_W;
  localparam int STEP_LATCH = STEP_LAST + 1;
  localparam int STEP_W     = $clog2(STEP_LATCH + 1);
  localparam logic [RES_W-1:0] MSB_ONE = {1'b1, {(RES_W-1){1'b0}}};

  // Keep or drop the bit under test, then raise the next lower bit.
  function automatic logic [RES_W-1:0] sar_next(input logic [RES_W-1:0] cur,
                                               input logic [RES_W-1:0] probe_v,
                                               input logic             keep);
    return (cur & ~probe_v) | (keep ? probe_v : '0) | (probe_v >> 1);
  endfunction

  logic [STEP_W-1:0] step;
  logic [RES_W-1:0]  probe;
  logic              at_trial, at_bit, at_latch, tick;

  always_comb begin
    tick     = busy && adc_ce && !start;
    at_trial = (step == STEP_W'(STEP_TRIAL));
    at_bit   = (step > STEP_W'(STEP_TRIAL)) && (step <= STEP_W'(STEP_LAST));
    at_latch = (step == STEP_W'(STEP_LATCH));
    res_load = tick && at_latch;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      step     <= '0;
      trial    <= '0;
      probe    <= '0;
      code_out <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      step  <= '0;
      trial <= '0;
      probe <= '0;
    end else if (tick) begin
      step <= step + 1'b1;
      if (at_trial) begin
        trial <= MSB_ONE;
        probe <= MSB_ONE;
      end else if (at_bit) begin
        trial <= sar_next(trial, probe, cmp_in);
        probe <= probe >> 1;
      end else if (at_latch) begin
        code_out <= trial;
        busy     <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/sar_adc_regs.sv
module sar_adc_regs
  import sar_adc_pkg::*;
#(
  parameter int RES_W  = 10,
  parameter int CHAN_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              busy,
  input  logic              res_load,
  input  logic [RES_W-1:0]  code,
  output logic              start,
  output logic              src_osc,
  output logic [DIV_W-1:0]  div_sel,
  output logic              done
);

  logic [CHAN_W-1:0] chan;
  logic              cfg_wr, lo_rd;
  logic              unused_wbits;

  always_comb begin
    start        = bus_we && (bus_addr == REG_CTRL);
    cfg_wr       = bus_we && (bus_addr == REG_CLKCFG);
    lo_rd        = bus_re && (bus_addr == REG_RES_LO);
    unused_wbits = ^bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan    <= '0;
      src_osc <= 1'b0;
      div_sel <= '0;
      done    <= 1'b0;
    end else begin
      if (start) chan <= bus_wdata[CHAN_W-1:0];
      if (cfg_wr) begin
        src_osc <= bus_wdata[DIV_W];
        div_sel <= bus_wdata[DIV_W-1:0];
      end
      if (start)         done <= 1'b0;
      else if (res_load) done <= 1'b1;
      else if (lo_rd)    done <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      REG_CTRL: begin
        bus_rdata[CHAN_W-1:0] = chan;
        bus_rdata[BUS_W-2]    = busy;
        bus_rdata[BUS_W-1]    = done;
      end
      REG_CLKCFG: begin
        bus_rdata[DIV_W-1:0] = div_sel;
        bus_rdata[DIV_W]     = src_osc;
      end
      REG_RES_HI: bus_rdata = BUS_W'(code >> BUS_W);
      default:    bus_rdata = code[BUS_W-1:0];
    endcase
  end

endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
  import sar_adc_pkg::*;
#(
  parameter int RES_W      = 10,
  parameter int SAMPLE_CYC = 5,
  parameter int CHAN_W     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              osc_tick,
  input  logic              cmp_in,
  output logic [RES_W-1:0]  dac_code
);

  // Named internal events, also watched by the bound checker.
  logic             start;
  logic             src_osc;
  logic [DIV_W-1:0] div_sel;
  logic             src_tick;
  logic             adc_ce;
  logic             busy;
  logic             res_load;
  logic             done;
  logic [RES_W-1:0] code;

  sar_adc_regs #(.RES_W(RES_W), .CHAN_W(CHAN_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy(busy), .res_load(res_load), .code(code),
    .start(start), .src_osc(src_osc), .div_sel(div_sel), .done(done)
  );

  sar_adc_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick),
    .src_osc(src_osc), .div_sel(div_sel),
    .src_tick(src_tick), .adc_ce(adc_ce)
  );

  sar_adc_sequencer #(.RES_W(RES_W), .SAMPLE_CYC(SAMPLE_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .adc_ce(adc_ce),
    .cmp_in(cmp_in), .busy(busy), .res_load(res_load),
    .trial(dac_code), .code_out(code)
  );

endmodule

// File: rtl/sar_adc_chk.sv
module sar_adc_chk #(
  parameter int RES_W      = 10,
  parameter int SAMPLE_CYC = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             adc_ce,
  input logic             src_tick,
  input logic             busy,
  input logic             res_load,
  input logic             done,
  input logic [RES_W-1:0] dac_code
);

  localparam int CE_TOTAL = SAMPLE_CYC + RES_W + 2;
  localparam int CNT_W    = $clog2(CE_TOTAL + 1);

  logic [CNT_W-1:0] ce_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               ce_seen <= '0;
    else if (start)           ce_seen <= '0;
    else if (busy && adc_ce)  ce_seen <= ce_seen + 1'b1;
  end

  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);  // R1
  AST_LATCH_ON_17TH: assert property (@(posedge clk) disable iff (!rst_n)
    res_load |-> (ce_seen == CNT_W'(CE_TOTAL - 1)));  // R2
  AST_NO_IDLE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !res_load);  // R2
  AST_CE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    adc_ce |-> src_tick);  // R3
  AST_LOAD_SETS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (res_load && !start) |=> done);  // R7
  AST_START_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !done);  // R8
  AST_DAC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!adc_ce && !start) |=> $stable(dac_code));  // R11

endmodule

bind sar_adc_ctrl sar_adc_chk #(.RES_W(RES_W), .SAMPLE_CYC(SAMPLE_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .adc_ce(adc_ce),
  .src_tick(src_tick), .busy(busy), .res_load(res_load),
  .done(done), .dac_code(dac_code)
);

// File: tb/sim_sar_adc_ctrl.sv
module sim_sar_adc_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int OSC_EVERY  = 3;
  localparam int NVEC       = 10;
  localparam int VIN [NVEC] = '{512, 1023, 0, 2000, -50, 341, 682, 1, 777, 5};
  localparam int SRC [NVEC] = '{0,   0,    0, 0,    0,   1,   0,   0, 1,   0};
  localparam int DIV [NVEC] = '{0,   1,    2, 0,    3,   0,   4,   6, 1,   7};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_we = 1'b0, bus_re = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       osc_tick;
  logic       cmp_in;
  logic [9:0] dac_code;
  int         vin = 0;
  int         osc_ph = 0;
  int         n_chk = 0, n_bad = 0;
  int         cyc = 0;
  bit         over = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) osc_ph <= (osc_ph == OSC_EVERY-1) ? 0 : osc_ph + 1;
  assign osc_tick = (osc_ph == OSC_EVERY-1);
  assign cmp_in   = (vin >= int'(dac_code));   // analog model: input vs DAC

  sar_adc_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .osc_tick(osc_tick), .cmp_in(cmp_in), .dac_code(dac_code)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int clamp_code(input int v);
    if (v <= 0) return 0;
    if (v >= 1023) return 1023;
    return v;
  endfunction

  function automatic int ratio_of(input int d);
    int r = 1;
    for (int i = 0; i < d && i < 4; i++) r = r * 2;
    return r;
  endfunction

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0; bus_addr = 2'd0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_re = 1'b1; #1; d = bus_rdata;
    @(negedge clk); bus_re = 1'b0; bus_addr = 2'd0;
  endtask

  // From the negedge right after the start edge, count edges until done.
  task automatic wait_done(input int limit, output int k);
    logic [7:0] s;
    k = 0;
    peek(2'd0, s);
    while (!s[7] && k < limit) begin
      @(negedge clk); k++; peek(2'd0, s);
    end
  endtask

  task automatic read_result(output int r);
    logic [7:0] h, l;
    rd(2'd2, h); rd(2'd3, l);
    r = int'({h[1:0], l});
  endtask

  initial begin
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 150000 && !over) begin
        n_bad++;
        $display("FAIL watchdog all-requirements actual=%0d expected=%0d", cyc, 150000);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] s;
    int k, res, m, lo, hi, held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: reset state
    for (int a = 0; a < 4; a++) begin
      peek(2'(a), s);
      check(s == 8'd0, "R10 reset register", int'(s), 0);
    end
    check(dac_code == 10'd0, "R10 reset dac_code", int'(dac_code), 0);

    // Vector table: source, ratio, input code
    for (int i = 0; i < NVEC; i++) begin
      vin = VIN[i];
      wr(2'd1, 8'((SRC[i] << 3) | DIV[i]));
      peek(2'd1, s);
      check(int'(s) == ((SRC[i] << 3) | DIV[i]), "R4 config readback", int'(s), (SRC[i] << 3) | DIV[i]);
      wr(2'd0, 8'((i + 3) % 32));
      peek(2'd0, s);
      check(s[6] == 1'b1 && int'(s[4:0]) == (i + 3) % 32, "R1 busy and channel", int'(s), 64 + (i + 3) % 32);
      m  = ratio_of(DIV[i]) * (SRC[i] != 0 ? OSC_EVERY : 1);
      lo = 16 * m + 1; hi = 17 * m;
      wait_done(hi + 20, k);
      check(k >= lo && k <= hi, "R2/R3/R4 latency window", k, lo);
      read_result(res);
      check(res == clamp_code(vin), "R5/R6 result code", res, clamp_code(vin));
      peek(2'd0, s);
      check(s[7] == 1'b0, "R7 done cleared by low read", int'(s[7]), 0);
    end

    // R8: restart during a conversion, bus clock divide 1
    wr(2'd1, 8'h00);
    vin = 900;
    wr(2'd0, 8'h01);
    repeat (5) @(negedge clk);
    vin = 100;
    wr(2'd0, 8'h02);
    wait_done(60, k);
    check(k == 17, "R8 restart timing from second write", k, 17);
    read_result(res);
    check(res == 100, "R8 restarted result", res, 100);

    // R9/R7/R11: config write and high read leave a finished result alone
    vin = 613;
    wr(2'd0, 8'h04);
    wait_done(60, k);
    check(k == 17, "R2 exact divide-1 latency", k, 17);
    held = int'(dac_code);
    wr(2'd1, 8'h02);
    peek(2'd0, s);
    check(s[7] == 1'b1 && s[6] == 1'b0, "R9 config write keeps done, no start", int'(s[7:6]), 2);
    check(int'(dac_code) == held && held == 613, "R11 dac_code held while idle", int'(dac_code), 613);
    rd(2'd2, s);
    check(int'(s) == (613 >> 8), "R9 result high kept", int'(s), 613 >> 8);
    peek(2'd0, s);
    check(s[7] == 1'b1, "R7 high read keeps done", int'(s[7]), 1);
    wr(2'd0, 8'h05);
    peek(2'd0, s);
    check(s[7] == 1'b0 && s[6] == 1'b1, "R8 write clears done", int'(s[7:6]), 1);
    wait_done(200, k);
    check(k >= 16 * 4 + 1 && k <= 17 * 4, "R4 divide-4 window", k, 65);
    read_result(res);
    check(res == 613, "R5 result after restart", res, 613);

    over = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule